// File: doc/BRIEF.md
# Slave-Mode Audio Clock Ratio Checker

This block watches the serial audio port while the port is a clock slave, with the bit clock and the frame clock arriving from outside. It runs on the master clock. It measures how many master clock cycles fall in each frame, and how many bit clock rising edges fall in each frame. It reports both measurements as ratio codes. A valid flag shows whether the pair is allowed for the selected speed mode and frame format. A locked flag shows whether the measurement has settled.

The frame clock is resynchronized into the master clock domain and its rising edges delimit frames. Bit clock edges are counted in their own domain, because the bit clock may run as fast as the master clock. Each per-frame count crosses to the master domain through a toggle handshake. A counter that saturates catches a frame clock that has stopped. A frame in which no bit clock count arrived is marked as unusable.

Top module: `clk_ratio_checker`

## Requirements
- R1: Out of reset, both ratio codes are 0, and `ratio_ok` and `locked` are 0.
- R2: `mck_ratio` encodes the master cycles per frame as 1=128, 2=192, 3=256, 4=384, 5=512, and 0 for any other count. It changes only after a frame edge.
- R3: `bit_ratio` encodes the bit clock rising edges per frame as 1=32, 2=48, 3=64, 4=128, 5=256, 6=512, and 0 for any other count.
- R4: With `tdm_mode`=0 and `dbl_rate`=0, a pair is valid when the master ratio is 256, 384 or 512 and the bit ratio is 32, 48, 64 or 128.
- R5: With `tdm_mode`=0 and `dbl_rate`=1, a pair is valid when the master ratio is 128, 192 or 256 and the bit ratio is 32, 48 or 64.
- R6: With `tdm_mode`=1 and `dbl_rate`=0, the only valid pairs (master, bit) are (256,256), (384,256) and (512,512).
- R7: With `tdm_mode`=1 and `dbl_rate`=1, the only valid pair is (256,256).
- R8: A pair with more bit clock edges than master cycles per frame is never valid.
- R9: `locked` rises only after two consecutive complete frames measure the same pair. After a stall, two frames are not enough.
- R10: If no frame edge arrives for 2^CNT_W-1 master cycles, `locked` and `ratio_ok` drop. A frame with no bit clock activity also clears both flags.
- R11: Changing `dbl_rate` or `tdm_mode` re-evaluates `ratio_ok` at once against the stored pair, without waiting for a new frame. It does not disturb `locked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| master_clk | input | 1 | Master clock; all outputs are in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk | input | 1 | Serial bit clock from the external master |
| frame_clk | input | 1 | Frame clock; a rising edge starts a frame |
| dbl_rate | input | 1 | 0 single speed, 1 double speed |
| tdm_mode | input | 1 | 0 left-justified/I2S, 1 TDM |
| mck_ratio | output | 3 | Master cycles per frame code |
| bit_ratio | output | 3 | Bit clock edges per frame code |
| ratio_ok | output | 1 | Stored pair is legal for the current mode |
| locked | output | 1 | Two consecutive frames matched |

## Verification
Several rules are checked on every master cycle:
- a valid flag never coexists with a bit ratio above the master ratio;
- `locked` only rises right after a frame edge;
- the codes hold steady between frame edges;
- saturation always clears both flags;
- in double-speed TDM, a valid flag always shows the single allowed pair.

The legality tables need the bench's scenarios. So do the exact ratio encodings, the two-frame lock delay after a stall, the loss of bit clock activity, and the immediate response to mode changes. The bench drives real bit and frame clocks with fractional periods against the master clock.

// File: rtl/clk_ratio_checker.sv
`timescale 1ns/1ps
module clk_ratio_checker #(
  parameter int CNT_W = 10
) (
  input  logic       master_clk,
  input  logic       rst_n,
  input  logic       bit_clk,
  input  logic       frame_clk,
  input  logic       dbl_rate,
  input  logic       tdm_mode,
  output logic [2:0] mck_ratio,
  output logic [2:0] bit_ratio,
  output logic       ratio_ok,
  output logic       locked
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  function automatic logic [2:0] mck_code(input int m);
    case (m)
      128: return 3'd1;
      192: return 3'd2;
      256: return 3'd3;
      384: return 3'd4;
      512: return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] bit_code(input int b);
    case (b)
      32:  return 3'd1;
      48:  return 3'd2;
      64:  return 3'd3;
      128: return 3'd4;
      256: return 3'd5;
      512: return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic pair_legal(input int m, input int b, input logic dbl, input logic tdm);
    logic m_ok, b_ok;
    if (b > m) return 1'b0;
    if (tdm) begin
      if (dbl) return (m == 256) && (b == 256);
      return ((m == 256 || m == 384) && b == 256) || (m == 512 && b == 512);
    end
    m_ok = dbl ? (m == 128 || m == 192 || m == 256) : (m == 256 || m == 384 || m == 512);
    b_ok = (b == 32) || (b == 48) || (b == 64) || (!dbl && b == 128);
    return m_ok && b_ok;
  endfunction

  // bit clock domain: edges per frame, handed over by toggle
  logic             fr_b, tog_b;
  logic [CNT_W-1:0] bcnt, bhold;
  wire fr_rise_b = frame_clk & ~fr_b;

  always_ff @(posedge bit_clk or negedge rst_n)
    if (!rst_n) begin
      fr_b  <= 1'b0;
      tog_b <= 1'b0;
      bcnt  <= '0;
      bhold <= '0;
    end else begin
      fr_b <= frame_clk;
      if (fr_rise_b) begin
        bhold <= bcnt;
        bcnt  <= CNT_W'(1);
        tog_b <= ~tog_b;
      end else if (bcnt != CMAX) begin
        bcnt <= bcnt + 1'b1;
      end
    end

  // master clock domain
  logic [2:0]       fr_s, tg_s;
  logic [CNT_W-1:0] mcnt, m_r, b_last, b_r;
  logic             b_seen, cap_ok, match;
  wire fr_edge = fr_s[1] & ~fr_s[2];
  wire b_new   = tg_s[1] ^ tg_s[2];
  wire m_sat   = (mcnt == CMAX);

  always_ff @(posedge master_clk or negedge rst_n)
    if (!rst_n) begin
      fr_s   <= '0;
      tg_s   <= '0;
      mcnt   <= '0;
      m_r    <= '0;
      b_r    <= '0;
      b_last <= '0;
      b_seen <= 1'b0;
      cap_ok <= 1'b0;
      match  <= 1'b0;
    end else begin
      fr_s <= {fr_s[1:0], frame_clk};
      tg_s <= {tg_s[1:0], tog_b};
      if (b_new) b_last <= bhold;
      if (fr_edge) begin
        m_r    <= mcnt;
        b_r    <= b_last;
        cap_ok <= !m_sat && b_seen;
        match  <= (mcnt == m_r) && (b_last == b_r) && !m_sat && b_seen && cap_ok;
        mcnt   <= CNT_W'(1);
        b_seen <= b_new;
      end else begin
        if (!m_sat) mcnt <= mcnt + 1'b1;
        if (b_new) b_seen <= 1'b1;
      end
    end

  assign mck_ratio = mck_code(int'(m_r));
  assign bit_ratio = bit_code(int'(b_r));
  assign ratio_ok  = cap_ok && !m_sat && pair_legal(int'(m_r), int'(b_r), dbl_rate, tdm_mode);
  assign locked    = match && !m_sat;

  assert_ok_slower_bit_R8: assert property (@(posedge master_clk) disable iff (!rst_n)
    ratio_ok |-> (b_r <= m_r));
  assert_lock_on_frame_R9: assert property (@(posedge master_clk) disable iff (!rst_n)
    $rose(locked) |-> $past(fr_edge));
  assert_codes_hold_R2: assert property (@(posedge master_clk) disable iff (!rst_n)
    !$past(fr_edge) |-> ($stable(mck_ratio) && $stable(bit_ratio)));
  assert_sat_drops_R10: assert property (@(posedge master_clk) disable iff (!rst_n)
    m_sat |-> (!locked && !ratio_ok));
  assert_tdm_dbl_pair_R7: assert property (@(posedge master_clk) disable iff (!rst_n)
    (ratio_ok && tdm_mode && dbl_rate) |-> (mck_ratio == 3'd3 && bit_ratio == 3'd5));
  assert_ok_has_codes_R3: assert property (@(posedge master_clk) disable iff (!rst_n)
    ratio_ok |-> (mck_ratio != 3'd0 && bit_ratio != 3'd0));
endmodule

// File: tb/clk_ratio_checker_test.sv
`timescale 1ns/1ps
module clk_ratio_checker_test;
  logic clk = 0, rst_n = 0, bck = 0, fck = 0, dbl = 0, tdm = 0;
  logic [2:0] mcode, scode;
  logic ok, lock;
  int checks = 0, fails = 0;
  bit done = 0;

  clk_ratio_checker uut (.master_clk(clk), .rst_n(rst_n), .bit_clk(bck), .frame_clk(fck),
    .dbl_rate(dbl), .tdm_mode(tdm), .mck_ratio(mcode), .bit_ratio(scode),
    .ratio_ok(ok), .locked(lock));

  always #4 clk = ~clk;

  function automatic int exp_m(int m);
    case (m) 128: return 1; 192: return 2; 256: return 3; 384: return 4; 512: return 5;
      default: return 0; endcase
  endfunction
  function automatic int exp_b(int b);
    case (b) 32: return 1; 48: return 2; 64: return 3; 128: return 4; 256: return 5;
      512: return 6; default: return 0; endcase
  endfunction
  function automatic int exp_ok(int m, int b, bit d, bit t);
    if (b > m) return 0;
    if (t && d) return int'(m == 256 && b == 256);
    if (t) return int'((b == 256 && (m == 256 || m == 384)) || (m == 512 && b == 512));
    if (d) return int'((m == 128 || m == 192 || m == 256) && (b == 32 || b == 48 || b == 64));
    return int'((m == 256 || m == 384 || m == 512) && (b == 32 || b == 48 || b == 64 || b == 128));
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(int m, int b, int n);
    real t0, per;
    @(posedge clk); #2;
    per = m * 8.0;
    for (int f = 0; f < n; f++) begin
      t0 = $realtime;
      if (b == 0) begin
        fck = 1; #((t0 + per / 2.0) - $realtime);
        fck = 0;
      end else begin
        for (int k = 0; k < 2 * b; k++) begin
          #((t0 + k * per / (2.0 * b)) - $realtime);
          if (k % 2 == 0) begin
            bck = 0;
            if (k == 0) fck = 1;
            if (k == b) fck = 0;
          end else bck = 1;
        end
      end
      #((t0 + per) - $realtime);
    end
  endtask

  task automatic verify(string req, int m, int b, int exp_lock);
    @(negedge clk);
    check({req, " mclk code"}, int'(mcode), exp_m(m));
    check({req, " bit code"}, int'(scode), exp_b(b));
    check({req, " ratio_ok"}, int'(ok), exp_ok(m, b, dbl, tdm));
    check({req, " locked"}, int'(lock), exp_lock);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  localparam int MS [5] = '{128, 192, 256, 384, 512};
  localparam int BS [6] = '{32, 48, 64, 128, 256, 512};

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 mclk code", int'(mcode), 0);
    check("R1 bit code", int'(scode), 0);
    check("R1 ratio_ok", int'(ok), 0);
    check("R1 locked", int'(lock), 0);
    rst_n = 1;

    dbl = 0; tdm = 0; run(256, 64, 5);  verify("R4 R2 R3", 256, 64, 1);
    run(512, 128, 5); verify("R4", 512, 128, 1);
    dbl = 1; run(192, 48, 5); verify("R5", 192, 48, 1);
    run(256, 128, 5); verify("R5 bit 128 illegal", 256, 128, 1);
    dbl = 0; tdm = 1; run(384, 256, 5); verify("R6", 384, 256, 1);
    run(512, 512, 5); verify("R6", 512, 512, 1);
    run(256, 64, 5); verify("R6 non-tdm pair", 256, 64, 1);
    dbl = 1; run(256, 256, 5); verify("R7", 256, 256, 1);
    dbl = 0; run(256, 512, 5); verify("R8", 256, 512, 1);

    tdm = 0;
    repeat (1100) @(posedge clk);
    run(256, 64, 2);
    @(negedge clk); check("R9 two frames after stall", int'(lock), 0);
    run(256, 64, 4); verify("R9 settled", 256, 64, 1);

    repeat (1100) @(posedge clk);
    @(negedge clk);
    check("R10 stall locked", int'(lock), 0);
    check("R10 stall ratio_ok", int'(ok), 0);
    run(256, 0, 5);
    @(negedge clk);
    check("R10 no bit clock ratio_ok", int'(ok), 0);
    check("R10 no bit clock locked", int'(lock), 0);

    run(256, 64, 5);
    @(negedge clk); check("R11 base ok", int'(ok), 1);
    tdm = 1;
    @(negedge clk);
    check("R11 to tdm ratio_ok", int'(ok), 0);
    check("R11 to tdm locked", int'(lock), 1);
    tdm = 0; dbl = 1;
    @(negedge clk);
    check("R11 to double ratio_ok", int'(ok), 1);

    for (int i = 0; i < 12; i++) begin
      int m, b;
      m = MS[$urandom_range(0, 4)];
      b = BS[$urandom_range(0, 5)];
      dbl = 1'($urandom_range(0, 1));
      tdm = 1'($urandom_range(0, 1));
      run(m, b, 5);
      verify("R2 R3 R4 R5 R6 R7 R8 random", m, b, 1);
    end
    finish_up();
  end
endmodule